// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the 32-bit exception status and control word that sits beside a floating-point arithmetic unit. It is big-endian numbered: bit 0 is the most significant bit, and the word is split into eight 4-bit fields. Field f covers bits 4f to 4f+3.

The word holds four kinds of state:
- sticky exception flags;
- sticky invalid-operation cause bits;
- two sticky rounding-detail bits;
- per-exception enable bits.

Three summary bits are derived from this state. The arithmetic unit reports its exceptions through a 14-bit event vector, one pulse per operation. Software acts on the word with four commands: set one bit, clear one bit, load a 4-bit immediate into a field, and copy a field to a 4-bit condition output.

All register bits update on the same rising clock edge. The order within one update is:
1. The software command is applied.
2. Hardware events are ORed on top.
3. The summaries are recomputed from the result.

Bits 15 to 20 and 29 to 31 are plain storage. Software can write them, and no hardware event touches them.

Top module: `fpx_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 bits and `cond_o` to zero.
- R2: Register bit n appears on `stat_o[31-n]`. Event bits map to register bits as follows:
  - `ev_i[0]`=overflow→3, `[1]`=underflow→4, `[2]`=divide-by-zero→5, `[3]`=inexact→6;
  - `[4]`=fraction rounded→13, `[5]`=fraction inexact→14;
  - `[6]`=signaling NaN→7, `[10:7]`=other invalid causes→8..11;
  - `[11]`=invalid compare→12, `[12]`=invalid square root→22, `[13]`=invalid convert→23.
  
  Bit 21 is the software-requested invalid cause.
- R3: Every bit except 1 and 2 keeps its value until a software command changes it.
- R4: Bit 2 always equals the OR of bits 7..12 and 21..23 of the updated word. A software write to bit 2 has no lasting effect.
- R5: Bit 0 is set in the update in which any of the following happens:
  - any exception event arrives (`ev_i` bits 0..3 or 6..13);
  - software sets one of bits 3..12 or 21..23.
  
  The rounding-detail events (`ev_i[4]`, `ev_i[5]`) alone do not set it.
- R6: Bit 1 is the OR of this cycle's raised exceptions, each ANDed with its enable:
  - any invalid cause with bit 24;
  - overflow with bit 25;
  - underflow with bit 26;
  - divide-by-zero with bit 27;
  - inexact with bit 28.
  
  The enables used are those after this cycle's software command. Bit 1 is 0 after a cycle with no such event, and software writes to it are ignored.
- R7: A cleared enable bit does not stop the matching flag from being set.
- R8: `op_i`=1 sets and `op_i`=2 clears register bit `idx_i`. Codes 0, 5, 6 and 7 change nothing.
- R9: `op_i`=3 loads `imm_i` into field `idx_i[2:0]`, with `imm_i[3]` going to the lowest-numbered bit 4f. Loading field 6 writes enables 24..27.
- R10: `op_i`=4 places field `idx_i[2:0]` on `cond_o` after the edge. The value is the field as it was before that edge, with bit 4f on `cond_o[3]`. At all other times `cond_o` holds its value.
- R11: When a hardware event and a software clear or field load hit the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Command: 0 none, 1 set bit, 2 clear bit, 3 load field, 4 read field |
| idx_i | input | 5 | Bit index, or field index in bits 2:0 |
| imm_i | input | 4 | Immediate for field load |
| ev_i | input | 14 | Exception event pulses from the arithmetic unit |
| stat_o | output | 32 | Register contents, bit n on stat_o[31-n] |
| cond_o | output | 4 | Field read result |

## Verification
The bench sweeps three areas:
- Every bit through set and clear, and every field through all sixteen immediates, each followed by a read-back. A design that reversed the field bit order or computed field offsets wrongly would show a mismatched word or condition value.
- Every single event, first with all enables cleared and then with all set. This exposes a design that gates flags on their enables, drops fraction-detail bits into the summary, or leaves the enabled-summary bit asserted after the operation.
- Same-cycle collisions: an event against a clear of its own flag, and an enable being set while its event arrives. These catch a design that lets software win the collision or sees stale enables.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int FLD_W  = 4;
    localparam int NFLD   = 8;
    localparam int REG_W  = FLD_W * NFLD;
    localparam int IDX_W  = $clog2(REG_W);
    localparam int FSEL_W = $clog2(NFLD);
    localparam int EV_W   = 14;
    localparam int NEN    = 5;

    // bit positions, 0 = most significant
    localparam int P_ANY   = 0;
    localparam int P_ENS   = 1;
    localparam int P_INV   = 2;
    localparam int P_OVF   = 3;
    localparam int P_UNF   = 4;
    localparam int P_DZ    = 5;
    localparam int P_INX   = 6;
    localparam int P_SNAN  = 7;
    localparam int P_VMISC = 8;
    localparam int P_CMP   = 12;
    localparam int P_FRND  = 13;
    localparam int P_FINX  = 14;
    localparam int P_SOFT  = 21;
    localparam int P_SQRT  = 22;
    localparam int P_CVT   = 23;
    localparam int P_EN0   = 24;

    typedef logic [0:REG_W-1] word_t;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_SETB = 3'd1,
        OP_CLRB = 3'd2,
        OP_WFLD = 3'd3,
        OP_RFLD = 3'd4
    } op_e;

    typedef struct packed {
        logic       cvt;
        logic       sqrt;
        logic       cmp;
        logic [3:0] vmisc;
        logic       snan;
        logic       fi;
        logic       fr;
        logic       inx;
        logic       dz;
        logic       unf;
        logic       ovf;
    } ev_t;

    function automatic logic is_cause(input int b);
        return ((b >= P_SNAN) && (b <= P_CMP)) || ((b >= P_SOFT) && (b <= P_CVT));
    endfunction

    function automatic logic is_flag(input int b);
        return ((b >= P_OVF) && (b <= P_CMP)) || ((b >= P_SOFT) && (b <= P_CVT));
    endfunction

    function automatic word_t cause_mask();
        word_t m;
        for (int b = 0; b < REG_W; b++) m[b] = is_cause(b);
        return m;
    endfunction

    function automatic word_t flag_mask();
        word_t m;
        for (int b = 0; b < REG_W; b++) m[b] = is_flag(b);
        return m;
    endfunction

endpackage

// File: rtl/fpx_event_map.sv
module fpx_event_map
    import fpx_pkg::*;
(
    input  ev_t              ev,
    input  logic [NEN-1:0]   en,      // [4]=invalid [3]=ovf [2]=unf [1]=dz [0]=inexact
    output word_t            hw_set,
    output logic             any_exc,
    output logic             ens_hit
);
    logic inv_raised;

    always_comb begin
        hw_set           = '0;
        hw_set[P_OVF]    = ev.ovf;
        hw_set[P_UNF]    = ev.unf;
        hw_set[P_DZ]     = ev.dz;
        hw_set[P_INX]    = ev.inx;
        hw_set[P_FRND]   = ev.fr;
        hw_set[P_FINX]   = ev.fi;
        hw_set[P_SNAN]   = ev.snan;
        hw_set[P_CMP]    = ev.cmp;
        hw_set[P_SQRT]   = ev.sqrt;
        hw_set[P_CVT]    = ev.cvt;
        for (int k = 0; k < 4; k++) begin
            hw_set[P_VMISC + k] = ev.vmisc[k];
        end
    end

    assign inv_raised = ev.snan | (|ev.vmisc) | ev.cmp | ev.sqrt | ev.cvt;
    assign any_exc    = inv_raised | ev.ovf | ev.unf | ev.dz | ev.inx;
    assign ens_hit    = (inv_raised & en[4]) | (ev.ovf & en[3]) | (ev.unf & en[2])
                      | (ev.dz & en[1]) | (ev.inx & en[0]);

endmodule

// File: rtl/fpx_cmd_decode.sv
module fpx_cmd_decode
    import fpx_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FLD_W-1:0]  imm,
    output word_t             sw_set,
    output word_t             sw_clr,
    output logic              sw_exc,
    output logic              rd_en,
    output logic [FSEL_W-1:0] rd_fld
);
    localparam word_t FLAGS = flag_mask();

    logic [FSEL_W-1:0] fsel;
    assign fsel   = idx[FSEL_W-1:0];
    assign rd_fld = fsel;

    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        rd_en  = 1'b0;
        case (op_e'(op))
            OP_SETB: sw_set[idx] = 1'b1;
            OP_CLRB: sw_clr[idx] = 1'b1;
            OP_WFLD: begin
                for (int f = 0; f < NFLD; f++) begin
                    if (fsel == FSEL_W'(f)) begin
                        for (int j = 0; j < FLD_W; j++) begin
                            sw_clr[f*FLD_W + j] = 1'b1;
                            sw_set[f*FLD_W + j] = imm[FLD_W-1-j];
                        end
                    end
                end
            end
            OP_RFLD: rd_en = 1'b1;
            default: ;
        endcase
    end

    assign sw_exc = |(sw_set & FLAGS);

endmodule

// File: rtl/fpx_field_read.sv
module fpx_field_read
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [FSEL_W-1:0] rd_fld,
    input  word_t             word,
    output logic [FLD_W-1:0]  cond_q
);
    logic [FLD_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int f = 0; f < NFLD; f++) begin
            if (rd_fld == FSEL_W'(f)) sel = word[f*FLD_W +: FLD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        cond_q <= '0;
        else if (rd_en) cond_q <= sel;
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(cond_q));

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [FLD_W-1:0]  imm_i,
    input  logic [EV_W-1:0]   ev_i,
    output logic [REG_W-1:0]  stat_o,
    output logic [FLD_W-1:0]  cond_o
);
    localparam word_t CAUSES = cause_mask();

    word_t             st_q, w_sw, w_nx;
    word_t             sw_set, sw_clr, hw_set;
    logic              sw_exc, any_exc, ens_hit, rd_en;
    logic [FSEL_W-1:0] rd_fld;
    logic [NEN-1:0]    en_now;

    fpx_cmd_decode u_dec (
        .op(op_i), .idx(idx_i), .imm(imm_i),
        .sw_set(sw_set), .sw_clr(sw_clr), .sw_exc(sw_exc),
        .rd_en(rd_en), .rd_fld(rd_fld)
    );

    assign w_sw = (st_q & ~sw_clr) | sw_set;

    // enables as they stand after this cycle's software command
    always_comb begin
        for (int k = 0; k < NEN; k++) en_now[NEN-1-k] = w_sw[P_EN0 + k];
    end

    fpx_event_map u_evm (
        .ev(ev_t'(ev_i)), .en(en_now),
        .hw_set(hw_set), .any_exc(any_exc), .ens_hit(ens_hit)
    );

    always_comb begin
        w_nx        = w_sw | hw_set;
        w_nx[P_ANY] = w_nx[P_ANY] | any_exc | sw_exc;
        w_nx[P_ENS] = ens_hit;
        w_nx[P_INV] = |(w_nx & CAUSES);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= w_nx;
    end

    fpx_field_read u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_fld(rd_fld),
        .word(st_q), .cond_q(cond_o)
    );

    assign stat_o = st_q;

    generate
        for (genvar i = 0; i < REG_W; i++) begin : g_chk
            if (i != P_ENS && i != P_INV) begin : g_sticky
                a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
                    ($past(st_q[i]) && !$past(sw_clr[i])) |-> st_q[i]);
            end
            a_r11_hw_wins: assert property (@(posedge clk) disable iff (rst)
                $past(hw_set[i]) |-> st_q[i]);
        end
    endgenerate

    a_r6_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !$past(any_exc) |-> !st_q[P_ENS]);

    a_r5_summary_follows: assert property (@(posedge clk) disable iff (rst)
        $past(any_exc) |-> st_q[P_ANY]);

endmodule

// File: tb/sim_fpx_status_reg.sv
module sim_fpx_status_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op;
    logic [4:0]  idx;
    logic [3:0]  imm;
    logic [13:0] ev;
    logic [31:0] stat;
    logic [3:0]  cond;

    int total = 0;
    int bad   = 0;
    logic [0:31] mdl;
    logic [3:0]  mcond;

    always #10 clk = ~clk;

    fpx_status_reg u0 (
        .clk(clk), .rst(rst), .op_i(op), .idx_i(idx), .imm_i(imm),
        .ev_i(ev), .stat_o(stat), .cond_o(cond)
    );

    function automatic int evpos(input int k);
        case (k)
            0: return 3;   1: return 4;   2: return 5;   3: return 6;
            4: return 13;  5: return 14;  6: return 7;   7: return 8;
            8: return 9;   9: return 10;  10: return 11; 11: return 12;
            12: return 22; default: return 23;
        endcase
    endfunction

    function automatic bit flagbit(input int b);
        return (b >= 3 && b <= 12) || (b >= 21 && b <= 23);
    endfunction

    function automatic bit causebit(input int b);
        return (b >= 7 && b <= 12) || (b >= 21 && b <= 23);
    endfunction

    task automatic step_model(input logic [2:0] o, input logic [4:0] x,
                              input logic [3:0] v, input logic [13:0] e);
        logic [0:31] w = mdl;
        logic swexc = 1'b0;
        logic inv, exc, fex, c;
        int fb = 4 * int'(x[2:0]);
        case (o)
            3'd1: begin w[x] = 1'b1; if (flagbit(int'(x))) swexc = 1'b1; end
            3'd2: w[x] = 1'b0;
            3'd3: for (int j = 0; j < 4; j++) begin
                      w[fb+j] = v[3-j];
                      if (v[3-j] && flagbit(fb+j)) swexc = 1'b1;
                  end
            3'd4: mcond = {mdl[fb], mdl[fb+1], mdl[fb+2], mdl[fb+3]};
            default: ;
        endcase
        inv = |e[13:6];
        exc = inv | (|e[3:0]);
        fex = (inv & w[24]) | (e[0] & w[25]) | (e[1] & w[26]) | (e[2] & w[27]) | (e[3] & w[28]);
        for (int k = 0; k < 14; k++) if (e[k]) w[evpos(k)] = 1'b1;
        if (exc || swexc) w[0] = 1'b1;
        w[1] = fex;
        c = 1'b0;
        for (int b = 0; b < 32; b++) if (causebit(b)) c = c | w[b];
        w[2] = c;
        mdl = w;
    endtask

    task automatic cyc(input logic [2:0] o, input int x, input logic [3:0] v,
                       input logic [13:0] e);
        op = o; idx = 5'(x); imm = v; ev = e;
        step_model(o, 5'(x), v, e);
        @(negedge clk);
        op = 3'd0; ev = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_stat(input string tag);
        logic [31:0] e = mdl;
        chk(tag, stat, e);
    endtask

    task automatic chk_cond(input string tag);
        chk(tag, {28'd0, cond}, {28'd0, mcond});
    endtask

    task automatic clear_flags();
        for (int f = 0; f < 6; f++) cyc(3'd3, f, 4'd0, '0);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r = 32'h1;
        op = '0; idx = '0; imm = '0; ev = '0; rst = 1'b1;
        mdl = '0; mcond = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 stat", stat, 32'd0);
        chk_cond("R1 cond");

        // R8 single-bit sweep; R4 bit 2 and R6 bit 1 overridden
        for (int b = 0; b < 32; b++) begin
            cyc(3'd1, b, 4'd0, '0);
            chk_stat(b == 2 ? "R4 set" : (b == 1 ? "R6 set" : "R8 set"));
            cyc(3'd4, b / 4, 4'd0, '0);
            chk_cond("R10 read");
            chk_stat("R3 after read");
            cyc(3'd2, b, 4'd0, '0);
            chk_stat("R8 clr");
        end
        for (int f = 0; f < 8; f++) cyc(3'd3, f, 4'd0, '0);

        // R9 field sweep with read-back
        for (int f = 0; f < 8; f++) begin
            for (int v = 0; v < 16; v++) begin
                cyc(3'd3, f, 4'(v), '0);
                chk_stat("R9 load");
                cyc(3'd4, f, 4'd0, '0);
                chk_cond("R10 field");
            end
            cyc(3'd3, f, 4'd0, '0);
            chk_stat("R9 zero");
        end

        // R2 R5 R6 R7 single events, enables off then on
        for (int cfg = 0; cfg < 2; cfg++) begin
            cyc(3'd3, 6, cfg ? 4'hf : 4'h0, '0);
            cyc(cfg ? 3'd1 : 3'd2, 28, 4'd0, '0);
            for (int k = 0; k < 14; k++) begin
                cyc(3'd0, 0, 4'd0, 14'(1 << k));
                chk_stat(cfg ? "R6 event" : "R7 event");
                chk(k < 4 || k > 5 ? "R5 summary" : "R2 detail",
                    {31'd0, stat[31]}, {31'd0, mdl[0]});
                cyc(3'd0, 0, 4'd0, '0);
                chk_stat("R6 idle");
                clear_flags();
            end
        end

        // R11 collisions and R6 same-cycle enable
        cyc(3'd3, 6, 4'h0, '0);
        cyc(3'd2, 28, 4'd0, '0);
        cyc(3'd1, 5, 4'd0, '0);
        cyc(3'd2, 5, 4'd0, 14'h0004);
        chk_stat("R11 clr vs dz");
        cyc(3'd3, 0, 4'd0, 14'h0001);
        chk_stat("R11 load vs ovf");
        clear_flags();
        cyc(3'd1, 25, 4'd0, 14'h0001);
        chk_stat("R6 same-cycle enable");
        cyc(3'd1, 21, 4'd0, '0);
        chk_stat("R5 R4 soft invalid");
        cyc(3'd4, 0, 4'd0, 14'h0002);
        chk_cond("R10 read before update");
        clear_flags();

        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [2:0] o;
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            o = 3'(r[2:0] % 5);
            cyc(o, int'(r[7:3]), r[11:8], r[13:0] & r[27:14] & {14{r[28]}});
            chk_stat("R3 mixed");
            if (o == 3'd4) chk_cond("R10 mixed");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule